// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers five interrupt sources for a small microcontroller core: two external pins, two timer overflow events and one serial port request. The serial request is formed from a receive flag and a transmit flag. An 8-bit enable register, which software reads and writes, gates the sources. It holds a master gate and one bit per source. Among the pending sources that are enabled, the block picks the one with the lowest vector address and presents that fixed 16-bit vector to the CPU on a request/acknowledge handshake.

Each external pin passes through a two-flop synchronizer. A per-pin trigger-type bit then selects level activation or falling-edge activation. Edge events and timer overflows are latched as pending flags, and the block clears each flag when the CPU acknowledges that source's vector. The serial flags belong to the serial port, and this block never clears them. After an acknowledge, an in-service flag holds back further requests until the CPU sends a return-from-interrupt pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While enable bit 7 (master gate) is 0, `cpuReq` stays low whatever the sources and per-source bits are.
- R2: With the master gate set, each source is gated by its own enable bit: bit 0 external pin 0, bit 1 timer 0, bit 2 external pin 1, bit 3 timer 1, bit 4 serial.
- R3: The vector for source index n (order as in R2) is 0003H + 8·n: 0003H, 000BH, 0013H, 001BH, 0023H.
- R4: The serial source is active while `serRx` or `serTx` is 1. An acknowledge does not clear it, so it requests again after the return pulse while a flag is still high.
- R5: When several enabled sources are pending, the lowest vector address wins.
- R6: Enable bits 6 and 5 always read back as 0. All other bits read back as written, and the read value is visible in the cycle after the write.
- R7: With `trigMode[e]`=0 (level), pin e requests while its synchronized level is low: the request appears two clock edges after the pin falls and drops two edges after it rises. Nothing is latched.
- R8: With `trigMode[e]`=1 (edge), a falling edge on pin e sets a pending flag three clock edges after the pin falls. The flag persists after the pin rises and is cleared by the acknowledge of that vector.
- R9: A one-cycle `timerOvf[t]` pulse sets the timer t pending flag at the next edge, and an acknowledge of its vector clears the flag. A new pulse in the same cycle as that acknowledge wins, and the flag stays set.
- R10: The cycle after an accepted acknowledge (`cpuAck` while `cpuReq`), `cpuReq` is low and stays low until a `cpuReti` pulse.
- R11: After reset, all enable bits are 0, no pending flags are set, the block is not in service, and `cpuReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the enable register |
| regWrData | input | 8 | Write data for the enable register |
| regRdData | output | 8 | Enable register read value |
| trigMode | input | 2 | Per-pin trigger type: 0 level, 1 falling edge |
| extPinN | input | 2 | External interrupt pins, active low, asynchronous |
| timerOvf | input | 2 | Timer overflow event pulses (bit 0 timer 0, bit 1 timer 1) |
| serRx | input | 1 | Serial receive flag |
| serTx | input | 1 | Serial transmit flag |
| cpuAck | input | 1 | CPU acknowledge of the presented vector |
| cpuReti | input | 1 | Return-from-interrupt pulse |
| cpuReq | output | 1 | Interrupt request to the CPU |
| cpuVector | output | 16 | Vector address of the winning source |

## Verification
An acknowledge that clears a timer's pending flag can coincide with a fresh overflow pulse from the same timer. The bench provokes this by raising `timerOvf[0]` in the very cycle that `cpuAck` is held. It judges the outcome after the return pulse: the request must come back with vector 000BH, which shows that the new event was not swallowed by the clear. A second pairing arises when a new timer pulse arrives while the block is in service. The request must stay low until `cpuReti`, and then it must present the waiting source.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC = 5;

  typedef struct packed {
    logic            take;
    logic [NSRC-1:0] grantOh;
  } ctlStrobe_t;
endpackage

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int          VEC_W       = 16,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter int          VEC_STRIDE  = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          NPIN        = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [NPIN-1:0]  trigMode,
  input  logic [NPIN-1:0]  extPinN,
  input  logic [NPIN-1:0]  timerOvf,
  input  logic             serRx,
  input  logic             serTx,
  input  ctlStrobe_t       strobe,
  output logic [NSRC-1:0]  reqMasked,
  output logic [VEC_W-1:0] cpuVector
);
  localparam logic [7:0] KEEP_MASK  = 8'h9F;
  localparam int         MASTER_BIT = 7;
  localparam int         SER_IDX    = 2 * NPIN;

  logic [7:0]      enReg;
  logic [NSRC-1:0] rawReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        enReg <= '0;
    else if (regWrEn) enReg <= regWrData & KEEP_MASK;
  end
  assign regRdData = enReg;

  for (genvar e = 0; e < NPIN; e++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncQ;
    logic lastQ, edgePend, tmrPend, pinLow, fallEdge;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        lastQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], extPinN[e]};
        lastQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign pinLow   = ~syncQ[SYNC_STAGES-1];
    assign fallEdge = lastQ & pinLow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        edgePend <= 1'b0;
      else if (!trigMode[e])                            edgePend <= 1'b0;
      else if (fallEdge)                                edgePend <= 1'b1;
      else if (strobe.take && strobe.grantOh[2*e])      edgePend <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        tmrPend <= 1'b0;
      else if (timerOvf[e])                             tmrPend <= 1'b1;
      else if (strobe.take && strobe.grantOh[2*e+1])    tmrPend <= 1'b0;
    end

    assign rawReq[2*e]   = trigMode[e] ? edgePend : pinLow;
    assign rawReq[2*e+1] = tmrPend;
  end

  assign rawReq[SER_IDX] = serRx | serTx;
  assign reqMasked = rawReq & enReg[NSRC-1:0] & {NSRC{enReg[MASTER_BIT]}};

  always_comb begin
    cpuVector = '0;
    for (int i = 0; i < NSRC; i++)
      if (strobe.grantOh[i]) cpuVector = VEC_BASE + VEC_W'(i * VEC_STRIDE);
  end
endmodule

// File: rtl/irqv_control.sv
module irqv_control
  import irqv_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqMasked,
  input  logic            cpuAck,
  input  logic            cpuReti,
  output logic            cpuReq,
  output ctlStrobe_t      strobe
);
  logic            inService;
  logic [NSRC-1:0] grant;

  assign grant  = reqMasked & (~reqMasked + NSRC'(1));
  assign cpuReq = (|reqMasked) & ~inService;

  assign strobe.take    = cpuReq & cpuAck;
  assign strobe.grantOh = grant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            inService <= 1'b0;
    else if (strobe.take) inService <= 1'b1;
    else if (cpuReti)     inService <= 1'b0;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int          VEC_W       = 16,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter int          VEC_STRIDE  = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [1:0]       trigMode,
  input  logic [1:0]       extPinN,
  input  logic [1:0]       timerOvf,
  input  logic             serRx,
  input  logic             serTx,
  input  logic             cpuAck,
  input  logic             cpuReti,
  output logic             cpuReq,
  output logic [VEC_W-1:0] cpuVector
);
  ctlStrobe_t      strobe;
  logic [NSRC-1:0] reqMasked;

  irqv_datapath #(
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .SYNC_STAGES(SYNC_STAGES), .NPIN(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .trigMode(trigMode), .extPinN(extPinN),
    .timerOvf(timerOvf), .serRx(serRx), .serTx(serTx), .strobe(strobe),
    .reqMasked(reqMasked), .cpuVector(cpuVector)
  );

  irqv_control u_ctl (
    .clk(clk), .rstN(rstN), .reqMasked(reqMasked), .cpuAck(cpuAck),
    .cpuReti(cpuReti), .cpuReq(cpuReq), .strobe(strobe)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  regRdData,
  input logic        cpuAck,
  input logic        cpuReq,
  input logic [15:0] cpuVector
);
  // R1: master gate low blocks every request
  a_r1_master_gate: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[7] |-> !cpuReq);

  // R2: a request needs at least one per-source enable
  a_r2_source_enable: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (|regRdData[4:0]));

  // R3: vector lies on the 8-byte grid from 0003H up to 0023H
  a_r3_vector_grid: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuVector[2:0] == 3'd3 && cpuVector[15:6] == '0 && cpuVector[5:3] <= 3'd4));

  // R6: reserved bits read as zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[6:5] == 2'b00);

  // R10: accepted acknowledge drops the request next cycle
  a_r10_in_service: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAck) |=> !cpuReq);
endmodule

bind irq_vector_ctrl irqv_checker u_chk (.*);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [1:0]  trigMode = 2'b00;
  logic [1:0]  extPinN = 2'b11;
  logic [1:0]  timerOvf = 2'b00;
  logic        serRx = 1'b0;
  logic        serTx = 1'b0;
  logic        cpuAck = 1'b0;
  logic        cpuReti = 1'b0;
  logic        cpuReq;
  logic [15:0] cpuVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (.*);

  // entry: {en[7:0], tmr[1:0], rx, tx, expReq, expVec[15:0]}
  localparam int NV = 10;
  localparam logic [28:0] VECS [NV] = '{
    {8'h00, 2'b01, 1'b0, 1'b0, 1'b0, 16'h0000},  // R1
    {8'h02, 2'b01, 1'b0, 1'b0, 1'b0, 16'h0000},  // R1
    {8'h82, 2'b01, 1'b0, 1'b0, 1'b1, 16'h000B},  // R2 R3
    {8'h81, 2'b01, 1'b0, 1'b0, 1'b0, 16'h0000},  // R2
    {8'h88, 2'b10, 1'b0, 1'b0, 1'b1, 16'h001B},  // R2 R3
    {8'h8A, 2'b11, 1'b0, 1'b0, 1'b1, 16'h000B},  // R5
    {8'h90, 2'b00, 1'b1, 1'b0, 1'b1, 16'h0023},  // R4
    {8'h90, 2'b00, 1'b0, 1'b1, 1'b1, 16'h0023},  // R4
    {8'h9F, 2'b10, 1'b1, 1'b0, 1'b1, 16'h001B},  // R5
    {8'hF0, 2'b00, 1'b1, 1'b0, 1'b1, 16'h0023}   // R6
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] v);
    regWrEn = 1'b1; regWrData = v; tick(); regWrEn = 1'b0;
  endtask

  task automatic ackCycle();
    cpuAck = 1'b1; tick(); cpuAck = 1'b0;
  endtask

  task automatic retiCycle();
    cpuReti = 1'b1; tick(); cpuReti = 1'b0;
  endtask

  task automatic drain();
    serRx = 1'b0; serTx = 1'b0; timerOvf = 2'b00;
    regWrite(8'h9F);
    for (int k = 0; k < 6; k++) if (cpuReq) begin ackCycle(); retiCycle(); end
    regWrite(8'h00);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) tick();
    rstN = 1'b1;
    tick();
    chk("R11 reset req", {31'd0, cpuReq}, 32'd0);
    chk("R11 reset enables", {24'd0, regRdData}, 32'd0);

    // table walk
    for (int n = 0; n < NV; n++) begin
      regWrEn = 1'b1; regWrData = VECS[n][28:21];
      timerOvf = VECS[n][20:19]; serRx = VECS[n][18]; serTx = VECS[n][17];
      tick();
      regWrEn = 1'b0; timerOvf = 2'b00;
      chk($sformatf("R1/R2/R4/R5 table %0d req", n), {31'd0, cpuReq}, {31'd0, VECS[n][16]});
      if (VECS[n][16])
        chk($sformatf("R3 table %0d vector", n), {16'd0, cpuVector}, {16'd0, VECS[n][15:0]});
      drain();
    end

    // R6 reserved readback
    regWrite(8'hFF);
    chk("R6 readback", {24'd0, regRdData}, 32'h9F);
    regWrite(8'h00);

    // R7 level mode on pin 0
    trigMode = 2'b00;
    regWrite(8'h81);
    extPinN[0] = 1'b0;
    tick();
    chk("R7 one edge after fall", {31'd0, cpuReq}, 32'd0);
    tick();
    chk("R7 level req", {31'd0, cpuReq}, 32'd1);
    chk("R7 level vector", {16'd0, cpuVector}, 32'h0003);
    ackCycle();
    chk("R10 blocked in service", {31'd0, cpuReq}, 32'd0);
    retiCycle();
    chk("R7 level re-request", {31'd0, cpuReq}, 32'd1);
    extPinN[0] = 1'b1;
    tick(); tick();
    chk("R7 level released", {31'd0, cpuReq}, 32'd0);

    // R8 edge mode on pin 1
    trigMode = 2'b10;
    regWrite(8'h84);
    extPinN[1] = 1'b0;
    tick(); tick();
    chk("R8 not yet latched", {31'd0, cpuReq}, 32'd0);
    tick();
    extPinN[1] = 1'b1;
    chk("R8 edge latched", {31'd0, cpuReq}, 32'd1);
    chk("R8 edge vector", {16'd0, cpuVector}, 32'h0013);
    repeat (3) tick();
    chk("R8 held after pin rise", {31'd0, cpuReq}, 32'd1);
    ackCycle();
    retiCycle();
    chk("R8 cleared by ack", {31'd0, cpuReq}, 32'd0);

    // R7 level mode latches nothing
    trigMode = 2'b00;
    extPinN[1] = 1'b0;
    repeat (3) tick();
    extPinN[1] = 1'b1;
    repeat (3) tick();
    chk("R7 no latch after release", {31'd0, cpuReq}, 32'd0);
    regWrite(8'h00);

    // R9 same-cycle ack and new overflow
    regWrite(8'h82);
    timerOvf = 2'b01; tick(); timerOvf = 2'b00;
    chk("R9 timer req", {31'd0, cpuReq}, 32'd1);
    cpuAck = 1'b1; timerOvf = 2'b01; tick(); cpuAck = 1'b0; timerOvf = 2'b00;
    chk("R10 blocked after ack", {31'd0, cpuReq}, 32'd0);
    retiCycle();
    chk("R9 set wins over clear", {31'd0, cpuReq}, 32'd1);
    chk("R9 vector", {16'd0, cpuVector}, 32'h000B);
    ackCycle();
    retiCycle();
    chk("R9 cleared by ack", {31'd0, cpuReq}, 32'd0);

    // R10 event during service waits for reti
    regWrite(8'h8A);
    timerOvf = 2'b01; tick(); timerOvf = 2'b00;
    ackCycle();
    timerOvf = 2'b10; tick(); timerOvf = 2'b00;
    tick();
    chk("R10 held while in service", {31'd0, cpuReq}, 32'd0);
    retiCycle();
    chk("R10 after reti req", {31'd0, cpuReq}, 32'd1);
    chk("R10 after reti vector", {16'd0, cpuVector}, 32'h001B);
    drain();

    // R4 serial flags not cleared by ack
    regWrite(8'h90);
    serTx = 1'b1; tick();
    chk("R4 serial req", {31'd0, cpuReq}, 32'd1);
    ackCycle();
    retiCycle();
    chk("R4 still requesting", {31'd0, cpuReq}, 32'd1);
    serTx = 1'b0; tick();
    chk("R4 drops with flags", {31'd0, cpuReq}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule